// File: doc/BRIEF.md
# Serial Cell Header Label Replacement Unit

This block sits after a cell delineation stage and rewrites the routing label at the head of each fixed-length cell as the cell passes bit by bit. It only acts once the delineation stage reports lock. When the lock flag is high and a cell-boundary pulse arrives, the block uses the parallel copy of the cell's old label to index a translation table that was loaded in advance through a write port. The table entry's replacement pattern is loaded into a parallel-to-serial shifter. A header-select window of fixed width, six bytes by default, then opens at a programmable number of bit times after the boundary, and the output multiplexer sends the serialized new pattern instead of the incoming bits.

The programmable delay covers the latency between the boundary pulse and the position of the old header in the stream, so that the new bits replace the old ones exactly. Outside the window, while lock is low, or when the table entry is marked invalid, the stream passes through unchanged. The output is one register stage behind the input.

Top module: `hov_top`

## Requirements
- R1: While `rst` is high at a clock edge, `dout` is 0 after that edge and no select window is open.
- R2: A clock edge with `tbl_we` high stores `tbl_wdata` and the valid flag `tbl_wvalid` at entry `tbl_waddr`. A later write to the same entry replaces both.
- R3: A clock edge with `cell_start` and `lock` both high looks up the entry whose index equals `old_id`. That entry alone supplies the replacement pattern for that cell.
- R4: Number the input bits of a cell from 0, where bit 0 is the bit sampled with `cell_start`. The window covers the `WIN_BITS` consecutive bits from bit number `delay_cfg` onward, with `delay_cfg` sampled at the `cell_start` edge.
- R5: A `delay_cfg` below 2 is treated as 2.
- R6: The window's k-th bit (k = 0 first) carries bit `WIN_BITS-1-k` of the table entry, so the most significant bit goes out first.
- R7: `dout` after clock edge n equals the selected bit for the input sampled at edge n. The output has one cycle of latency.
- R8: Outside the window, `dout` reproduces `din` delayed by one cycle.
- R9: If the looked-up entry's valid flag is 0, no window opens and the whole cell passes through unchanged.
- R10: A `cell_start` sampled with `lock` low starts no window. Any bit sampled while `lock` is low passes through unchanged, even inside an open window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| cell_start | input | 1 | Cell-boundary pulse, high with bit 0 of a cell |
| lock | input | 1 | Delineation lock flag |
| old_id | input | IDX_W | Old label of the current cell, used as table index |
| din | input | 1 | Incoming serial cell stream |
| delay_cfg | input | DLY_W | Window offset in bit times from the boundary |
| tbl_we | input | 1 | Table write strobe |
| tbl_waddr | input | IDX_W | Table write index |
| tbl_wdata | input | WIN_BITS | Replacement pattern to store |
| tbl_wvalid | input | 1 | Valid flag to store with the pattern |
| dout | output | 1 | Outgoing serial stream, registered |

## Verification
The bench uses the default parameters: a 64-entry table indexed by a 6-bit label, a 48-bit window, and a 9-bit delay. With these values every table index, including the top entry 63, can be reached. The delay sweeps from the clamped values 0 and 1 up to 376, where the window ends on the last bit of a 424-bit cell. A reference model of the table and the window predicts every output bit across hit, miss, rewritten-entry, lock-low and mid-window lock-drop cells.

// File: rtl/hov_pkg.sv
package hov_pkg;
  // smallest usable window offset: one cycle for the table read,
  // one cycle to load the shifter
  localparam int unsigned HOV_MIN_DLY = 2;
endpackage

// File: rtl/hov_table.sv
module hov_table #(
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned DATA_W = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wvalid,
  input  logic              re,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_hit
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  // pattern storage: no reset, registered read, so block RAM fits
  logic [DATA_W-1:0] mem [DEPTH];
  // valid flags in flops so reset empties the table
  logic [DEPTH-1:0]  vld;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rd_data <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld    <= '0;
      rd_hit <= 1'b0;
    end else begin
      if (we) vld[waddr] <= wvalid;
      if (re) rd_hit <= vld[raddr];
    end
  end
endmodule

// File: rtl/hov_win_timer.sv
module hov_win_timer #(
  parameter int unsigned DLY_W    = 9,
  parameter int unsigned WIN_BITS = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic [DLY_W-1:0] dly_eff,
  input  logic             hit,
  output logic             load,
  output logic             win_on
);
  localparam int unsigned CNT_W = (WIN_BITS > 1) ? $clog2(WIN_BITS) : 1;

  logic             armed;
  logic [DLY_W-1:0] cnt;
  logic [CNT_W-1:0] bitcnt;

  // the shifter is loaded one cycle before the first window bit
  assign load = armed && (cnt == DLY_W'(1)) && !arm;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed  <= 1'b0;
      cnt    <= '0;
      win_on <= 1'b0;
      bitcnt <= '0;
    end else begin
      if (arm) begin
        armed <= 1'b1;
        cnt   <= dly_eff - DLY_W'(1);
      end else if (armed) begin
        if (cnt == DLY_W'(1)) armed <= 1'b0;
        cnt <= cnt - DLY_W'(1);
      end

      if (load) begin
        win_on <= hit;
        bitcnt <= CNT_W'(WIN_BITS - 1);
      end else if (win_on) begin
        if (bitcnt == '0) win_on <= 1'b0;
        else              bitcnt <= bitcnt - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/hov_ser.sv
module hov_ser #(
  parameter int unsigned WIN_BITS = 48
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                shift,
  input  logic [WIN_BITS-1:0] pdata,
  output logic                sbit
);
  logic [WIN_BITS-1:0] sh;

  assign sbit = sh[WIN_BITS-1];

  generate
    if (WIN_BITS > 1) begin : g_wide
      always_ff @(posedge clk) begin
        if (rst)        sh <= '0;
        else if (load)  sh <= pdata;
        else if (shift) sh <= {sh[WIN_BITS-2:0], 1'b0};
      end
    end else begin : g_one
      always_ff @(posedge clk) begin
        if (rst)        sh <= '0;
        else if (load)  sh <= pdata;
        else if (shift) sh <= '0;
      end
    end
  endgenerate
endmodule

// File: rtl/hov_top.sv
module hov_top #(
  parameter int unsigned IDX_W    = 6,
  parameter int unsigned WIN_BITS = 48,
  parameter int unsigned DLY_W    = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cell_start,
  input  logic                lock,
  input  logic [IDX_W-1:0]    old_id,
  input  logic                din,
  input  logic [DLY_W-1:0]    delay_cfg,
  input  logic                tbl_we,
  input  logic [IDX_W-1:0]    tbl_waddr,
  input  logic [WIN_BITS-1:0] tbl_wdata,
  input  logic                tbl_wvalid,
  output logic                dout
);
  import hov_pkg::*;

  localparam logic [DLY_W-1:0] MIN_D = DLY_W'(HOV_MIN_DLY);

  logic                arm;
  logic [DLY_W-1:0]    dly_eff;
  logic [WIN_BITS-1:0] rd_data;
  logic                hit_q;
  logic                load;
  logic                win_on;
  logic                new_bit;
  logic                sel;

  assign arm     = cell_start & lock;
  assign dly_eff = (delay_cfg < MIN_D) ? MIN_D : delay_cfg;

  hov_table #(.IDX_W(IDX_W), .DATA_W(WIN_BITS)) u_tbl (
    .clk(clk), .rst(rst),
    .we(tbl_we), .waddr(tbl_waddr), .wdata(tbl_wdata), .wvalid(tbl_wvalid),
    .re(arm), .raddr(old_id),
    .rd_data(rd_data), .rd_hit(hit_q)
  );

  hov_win_timer #(.DLY_W(DLY_W), .WIN_BITS(WIN_BITS)) u_tmr (
    .clk(clk), .rst(rst),
    .arm(arm), .dly_eff(dly_eff), .hit(hit_q),
    .load(load), .win_on(win_on)
  );

  hov_ser #(.WIN_BITS(WIN_BITS)) u_ser (
    .clk(clk), .rst(rst),
    .load(load), .shift(win_on), .pdata(rd_data),
    .sbit(new_bit)
  );

  // 2:1 select: generated header inside the window while locked
  assign sel = win_on & lock;

  always_ff @(posedge clk) begin
    if (rst) dout <= 1'b0;
    else     dout <= sel ? new_bit : din;
  end
endmodule

// File: rtl/hov_chk.sv
module hov_chk #(
  parameter int unsigned WIN_BITS = 48,
  parameter int unsigned DLY_W    = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             cell_start,
  input logic             lock,
  input logic             din,
  input logic [DLY_W-1:0] delay_cfg,
  input logic             dout,
  input logic             win_on,
  input logic             hit_q
);
  import hov_pkg::*;

  logic [15:0]      run;
  logic [DLY_W:0]   since;
  logic [DLY_W:0]   dcap;

  always_ff @(posedge clk) begin
    if (rst) begin
      run   <= '0;
      since <= '0;
      dcap  <= '0;
    end else begin
      run <= win_on ? run + 16'd1 : 16'd0;
      if (cell_start && lock) begin
        since <= '0;
        dcap  <= (delay_cfg < DLY_W'(HOV_MIN_DLY)) ? (DLY_W+1)'(HOV_MIN_DLY)
                                                  : {1'b0, delay_cfg};
      end else if (since != '1) begin
        since <= since + 1'b1;
      end
    end
  end

  // R8
  outside_window_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(win_on)) |-> (dout == $past(din)));

  // R10
  lock_passthru_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(lock)) |-> (dout == $past(din)));

  // R4
  win_length_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(win_on) |-> (run == 16'(WIN_BITS)));

  // R5
  win_delay_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(win_on) |-> (since + 1'b1 == dcap));

  // R9
  miss_no_window_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(win_on) |-> $past(hit_q));
endmodule

bind hov_top hov_chk #(.WIN_BITS(WIN_BITS), .DLY_W(DLY_W)) u_chk (
  .clk(clk), .rst(rst), .cell_start(cell_start), .lock(lock), .din(din),
  .delay_cfg(delay_cfg), .dout(dout), .win_on(win_on), .hit_q(hit_q)
);

// File: tb/hov_top_test.sv
module hov_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 6;
  localparam int WIN   = 48;
  localparam int DLY_W = 9;
  localparam int CELL  = 424;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cell_start = 1'b0;
  logic             lock = 1'b0;
  logic [IDX_W-1:0] old_id = '0;
  logic             din = 1'b0;
  logic [DLY_W-1:0] delay_cfg = '0;
  logic             tbl_we = 1'b0;
  logic [IDX_W-1:0] tbl_waddr = '0;
  logic [WIN-1:0]   tbl_wdata = '0;
  logic             tbl_wvalid = 1'b0;
  logic             dout;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [WIN-1:0] m_data [64];
  bit             m_vld  [64];

  bit    exp_q [$];
  string tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  hov_top #(.IDX_W(IDX_W), .WIN_BITS(WIN), .DLY_W(DLY_W)) uut (
    .clk(clk), .rst(rst), .cell_start(cell_start), .lock(lock),
    .old_id(old_id), .din(din), .delay_cfg(delay_cfg),
    .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
    .tbl_wvalid(tbl_wvalid), .dout(dout)
  );

  task automatic check(input bit act, input bit exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      if (n_bad < 20) $display("FAIL %s: dout=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // driver step: one input bit, expectation pushed to the scoreboard
  task automatic step(input bit st, input bit lk, input bit b, input bit e, input string tag);
    @(negedge clk);
    cell_start = st; lock = lk; din = b;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // monitor: pops one expectation per clock after the output register
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      automatic bit    e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      check(dout, e, t);
    end
  end

  function automatic logic [WIN-1:0] pat(input int s);
    return 48'h5A3C_0F96_E1B4 ^ (48'(s) * 48'h0001_0203_0405);
  endfunction

  task automatic wr_entry(input int idx, input logic [WIN-1:0] d, input bit v);
    step(0, 1, 0, 0, "R2");
    tbl_we = 1; tbl_waddr = IDX_W'(idx); tbl_wdata = d; tbl_wvalid = v;
    step(0, 1, 0, 0, "R2");
    tbl_we = 0;
    m_data[idx] = d; m_vld[idx] = v;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      automatic bit b = 1'($urandom);
      step(0, 1, b, b, tag);
    end
  endtask

  // one full cell; lock low for bits in [dlo, dhi); base is lock level of the cell
  task automatic send_cell(input int id, input int cfg, input bit base,
                           input int dlo, input int dhi, input string tag);
    automatic int d = (cfg < 2) ? 2 : cfg;
    old_id = IDX_W'(id);
    delay_cfg = DLY_W'(cfg);
    for (int i = 0; i < CELL; i++) begin
      automatic bit b  = 1'($urandom);
      automatic bit lk = (i >= dlo && i < dhi) ? 1'b0 : base;
      automatic bit inw = base && m_vld[id] && (i >= d) && (i < d + WIN);
      automatic bit e  = (inw && lk) ? m_data[id][WIN-1-(i-d)] : b;
      automatic string t = inw ? (lk ? tag : "R10") : (base ? "R8" : "R10");
      step(i == 0, lk, b, e, t);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin m_data[i] = '0; m_vld[i] = 0; end
    din = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(dout, 1'b0, "R1");
    @(negedge clk);
    rst = 1'b0;
    lock = 1'b1;

    idle(20, "R7");
    wr_entry(3,  pat(3), 1);
    wr_entry(10, pat(10), 1);
    wr_entry(63, pat(63), 1);
    wr_entry(5,  pat(5), 0);
    wr_entry(7,  pat(7), 1);
    wr_entry(7,  pat(7), 0);
    idle(4, "R8");

    send_cell(3, 40, 1, -1, -1, "R3");   idle(3, "R8");
    send_cell(10, 2, 1, -1, -1, "R4");   idle(3, "R8");
    send_cell(63, 300, 1, -1, -1, "R6"); idle(3, "R8");
    send_cell(3, 376, 1, -1, -1, "R4");  idle(3, "R8");
    send_cell(3, 0, 1, -1, -1, "R5");    idle(3, "R8");
    send_cell(10, 1, 1, -1, -1, "R5");   idle(3, "R8");
    send_cell(5, 20, 1, -1, -1, "R9");   idle(3, "R8");
    send_cell(7, 20, 1, -1, -1, "R9");   idle(3, "R8");
    send_cell(3, 20, 0, -1, -1, "R10");  idle(3, "R8");
    send_cell(63, 30, 1, 45, 60, "R10"); idle(3, "R8");
    wr_entry(3, pat(99), 1);
    send_cell(3, 25, 1, -1, -1, "R2");   idle(3, "R8");
    wr_entry(3, pat(99), 0);
    send_cell(3, 25, 1, -1, -1, "R9");
    idle(10, "R7");

    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule